// File: doc/BRIEF.md
# Serpentine Tiled Texture Address Generator

This block converts a pixel coordinate into the byte offset of that pixel inside a three-level tiled texture whose pixels are 4 bytes each. A 64-byte micro-tile holds 4x4 pixels. A 1 KB sub-tile holds a 4x4 grid of micro-tiles. A 4 KB tile holds a 2x2 grid of sub-tiles, so it covers 32x32 pixels. Memory starts at the bottom-left corner of the image, and rows of tiles run in a serpentine pattern. The order of the four sub-tiles inside a tile depends on whether the tile row is even or odd.

The block has two ways of working. In lookup mode, a coordinate is presented on a valid/ready request port and its offset comes back one cycle later on a valid/ready result port. In sequencing mode, a single start pulse makes the block walk every pixel of the image in raster order, starting at the bottom row. It emits one offset per cycle while the result port is ready, and pulses a done flag after the last pixel. Coordinates are counted from the bottom-left pixel: y = 0 is the bottom row. The image dimensions are given in pixels and must stay stable while the block is in use.

Top module: `serp_tile_addr`

## Requirements
- R1: Inside a micro-tile, the pixel at local column px (0..3) and local row py (0..3, counted from the bottom) lies at byte 4*(4*py + px) of the micro-tile.
- R2: Inside a sub-tile, the micro-tile at column ux (0..3) and row uy (0..3, counted from the bottom) starts at byte 64*(4*uy + ux) of the sub-tile.
- R3: On an even tile row, counted from the bottom of the image, the sub-tiles occupy these slots, each slot being 1024 bytes: bottom-left slot 0, top-left slot 1, top-right slot 2, bottom-right slot 3.
- R4: On an odd tile row, the sub-tiles occupy these slots: top-right slot 0, bottom-right slot 1, bottom-left slot 2, top-left slot 3.
- R5: Tile row r, with W tiles per row (W = image width / 32), starts at tile index r*W. On even rows the tiles run left to right. On odd rows they run right to left. Each tile index is worth 4096 bytes, and pixel (0,0) is at offset 0.
- R6: A request is taken on a cycle where req_valid and req_ready are both high. Its offset appears with res_valid on the next cycle. While res_ready is low, res_valid and res_offset hold and no new request is taken.
- R7: A seq_start pulse, when the block is idle and align_err is low, starts a walk. The walk emits offsets for y = 0 up to height-1 and, within each row, x = 0 up to width-1, one per cycle without gaps while res_ready is high.
- R8: req_ready is low for the whole walk. seq_done is high for exactly one cycle: the cycle after the handshake of the walk's last offset.
- R9: align_err is high when the width or height is zero or not a multiple of 32. While it is high, seq_start is ignored and req_ready stays high.
- R10: After reset, res_valid and seq_done are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| img_w | input | CW | Image width in pixels |
| img_h | input | CW | Image height in pixels |
| align_err | output | 1 | Dimensions are zero or not multiples of 32 |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_x | input | CW | Pixel column, from the left |
| req_y | input | CW | Pixel row, from the bottom |
| seq_start | input | 1 | Start a full-image walk |
| seq_done | output | 1 | One-cycle pulse after the walk's last offset |
| res_valid | output | 1 | Result offset valid |
| res_ready | input | 1 | Result consumer ready |
| res_offset | output | OW | Byte offset of the pixel |

## Verification
Single lookups are placed directly into each of the four sub-tile quadrants, on both an even and an odd tile row. This separates the two sub-tile orders from each other and from a plain raster order. Lookups are also placed in an odd tile row of a multi-tile-wide image, which shows whether the reversed tile direction is present. Small in-tile steps separate the micro-tile term from the pixel term. Random lookups over random widths mix all the terms together. Full walks are run with random backpressure, which tests the hold behaviour and the raster order, and at full rate, which tests that the stream has no gaps. The done pulse is checked against the exact beat count. A misaligned width is used to show that a start request is refused.

// File: rtl/serp_tile_addr.sv
module serp_tile_addr #(
  parameter int CW = 12,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] img_w,
  input  logic [CW-1:0] img_h,
  output logic          align_err,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_x,
  input  logic [CW-1:0] req_y,
  input  logic          seq_start,
  output logic          seq_done,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [OW-1:0] res_offset
);
  localparam int TW = CW - 5;
  localparam logic [CW-1:0] ONE = 1;

  logic          busy, res_last, advance, start_ok, at_end, row_end;
  logic [CW-1:0] cx, cy;
  logic [TW-1:0] tiles_w;

  function automatic logic [OW-1:0] locate(input logic [CW-1:0] px, input logic [CW-1:0] py,
                                           input logic [TW-1:0] tw);
    logic [TW-1:0] tr, tc, col;
    logic [1:0]    sub;
    logic [OW-1:0] tidx;
    tr   = py[CW-1:5];
    tc   = px[CW-1:5];
    col  = tr[0] ? (tw - TW'(1) - tc) : tc;
    sub  = {px[4] ^ tr[0], px[4] ^ py[4]};
    tidx = OW'(tr) * OW'(tw) + OW'(col);
    return (tidx << 12) | OW'({sub, py[3:2], px[3:2], py[1:0], px[1:0], 2'b00});
  endfunction

  assign tiles_w   = img_w[CW-1:5];
  assign align_err = (|img_w[4:0]) | (|img_h[4:0]) | (img_w == '0) | (img_h == '0);
  assign advance   = !res_valid || res_ready;
  assign req_ready = !busy && advance;
  assign start_ok  = seq_start && !busy && !align_err;
  assign row_end   = (cx == img_w - ONE);
  assign at_end    = row_end && (cy == img_h - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cx         <= '0;
      cy         <= '0;
      res_valid  <= 1'b0;
      res_offset <= '0;
      res_last   <= 1'b0;
      seq_done   <= 1'b0;
    end else begin
      seq_done <= res_valid && res_ready && res_last;
      if (start_ok) begin
        busy <= 1'b1;
        cx   <= '0;
        cy   <= '0;
      end
      if (advance) begin
        if (busy) begin
          res_valid  <= 1'b1;
          res_offset <= locate(cx, cy, tiles_w);
          res_last   <= at_end;
          if (at_end) busy <= 1'b0;
          else if (row_end) begin
            cx <= '0;
            cy <= cy + ONE;
          end else cx <= cx + ONE;
        end else if (req_valid) begin
          res_valid  <= 1'b1;
          res_offset <= locate(req_x, req_y, tiles_w);
          res_last   <= 1'b0;
        end else begin
          res_valid <= 1'b0;
          res_last  <= 1'b0;
        end
      end
    end
  end
endmodule

module serp_tile_addr_chk #(
  parameter int CW = 12,
  parameter int OW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          align_err,
  input logic          req_valid,
  input logic          req_ready,
  input logic          seq_start,
  input logic          seq_done,
  input logic          res_valid,
  input logic          res_ready,
  input logic [OW-1:0] res_offset
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_offset));
  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
  assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(res_valid && res_ready));
  assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err && seq_start && !req_valid && req_ready && !res_valid |=> req_ready);
endmodule

bind serp_tile_addr serp_tile_addr_chk #(.CW(CW), .OW(OW)) u_chk (.*);

// File: tb/sim_serp_tile_addr.sv
module sim_serp_tile_addr;
  localparam int CW = 12;
  localparam int OW = 32;

  logic          clk = 0, rst_n = 0;
  logic [CW-1:0] img_w = 64, img_h = 64, req_x = 0, req_y = 0;
  logic          req_valid = 0, seq_start = 0, res_ready = 1;
  logic          align_err, req_ready, seq_done, res_valid;
  logic [OW-1:0] res_offset;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  serp_tile_addr #(.CW(CW), .OW(OW)) u0 (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  function automatic longint model(int x, int y, int wt);
    int tr, tc, col, sx, sy, sub;
    tr = y / 32; tc = x / 32;
    col = (tr % 2 == 0) ? tc : wt - 1 - tc;
    sx = (x % 32) / 16; sy = (y % 32) / 16;
    if (tr % 2 == 0) sub = (sx == 0) ? ((sy == 0) ? 0 : 1) : ((sy == 1) ? 2 : 3);
    else             sub = (sx == 1) ? ((sy == 1) ? 0 : 1) : ((sy == 0) ? 2 : 3);
    return longint'(tr * wt + col) * 4096 + sub * 1024
         + (((y % 16) / 4) * 4 + (x % 16) / 4) * 64 + ((y % 4) * 4 + x % 4) * 4;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(string tag, int x, int y, int w);
    @(negedge clk);
    img_w = CW'(w); img_h = 256; req_x = CW'(x); req_y = CW'(y);
    req_valid = 1; res_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, res_valid, 1);
    chk(tag, res_offset, model(x, y, w / 32));
  endtask

  task automatic run_seq(int w, int h, bit full);
    int k = 0, gaps = 0;
    bit done = 0;
    @(negedge clk);
    img_w = CW'(w); img_h = CW'(h); seq_start = 1; res_ready = 1;
    @(negedge clk);
    seq_start = 0;
    chk("R8 req_ready low during walk", req_ready, 0);
    while (!done) begin
      res_ready = full ? 1'b1 : ($urandom % 4 != 0);
      #1;
      if (seq_done) begin
        done = 1;
        chk("R8 done after last beat", k, w * h);
      end else if (res_valid) begin
        if (res_ready) begin
          if (res_offset != OW'(model(k % w, k / w, w / 32)))
            chk("R7 walk offset", res_offset, model(k % w, k / w, w / 32));
          k++;
        end
      end else if (k > 0) gaps++;
      @(negedge clk);
    end
    checks++;
    chk("R8 done is one cycle", seq_done, 0);
    if (full) chk("R7 no gaps at full rate", gaps, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 res_valid", res_valid, 0);
    chk("R10 seq_done", seq_done, 0);
    chk("R10 req_ready", req_ready, 1);

    look("R1 pixel in micro-tile", 1, 2, 64);
    look("R1 pixel corner", 3, 3, 64);
    look("R2 micro-tile in sub-tile", 4, 8, 64);
    look("R2 micro-tile corner", 12, 12, 64);
    look("R3 even BL", 5, 5, 64);
    look("R3 even TL", 5, 21, 64);
    look("R3 even TR", 21, 21, 64);
    look("R3 even BR", 21, 5, 64);
    look("R4 odd TR", 21, 53, 64);
    look("R4 odd BR", 21, 37, 64);
    look("R4 odd BL", 5, 37, 64);
    look("R4 odd TL", 5, 53, 64);
    look("R5 origin", 0, 0, 96);
    look("R5 even row tile 2", 70, 3, 96);
    look("R5 odd row leftmost", 0, 32, 96);
    look("R5 odd row rightmost", 95, 63, 96);

    for (int i = 0; i < 60; i++) begin
      int w = 32 * (1 + $urandom % 8);
      look("R5 random lookup", $urandom % w, $urandom % 256, w);
    end

    @(negedge clk);
    img_w = 64; req_x = 40; req_y = 40; req_valid = 1; res_ready = 0;
    @(negedge clk);
    req_x = 7; req_y = 9;
    repeat (3) begin
      @(negedge clk);
      chk("R6 hold valid", res_valid, 1);
      chk("R6 hold offset", res_offset, model(40, 40, 2));
      chk("R6 stalled req_ready", req_ready, 0);
    end
    req_valid = 0; res_ready = 1;
    @(negedge clk);

    run_seq(64, 64, 0);
    run_seq(96, 32, 1);

    @(negedge clk);
    img_w = 40; img_h = 64; seq_start = 1;
    #1 chk("R9 align_err width", align_err, 1);
    @(negedge clk);
    seq_start = 0;
    chk("R9 start refused", req_ready, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R9 no output", res_valid, 0);
    end
    img_w = 64; img_h = 0;
    #1 chk("R9 align_err zero height", align_err, 1);
    img_h = 64;
    #1 chk("R9 aligned", align_err, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule